// File: doc/BRIEF.md
# Watchdog Event Reset Router

This block takes timeout events from six watchdog timer channels and turns each one into a reset or interrupt action. Every channel has its own control register. The register selects what a timer event does: nothing, a local core reset, a non-maskable interrupt (NMI), an NMI followed by a local reset after a programmable delay, or a system reset request. The register also records that an event arrived, in a sticky status flag, and holds a write lock. The NMI, local-reset and system-reset outputs are shared by all channels. Software reads each channel's status flag to find out which timer fired.

Software reaches the registers through a simple port. A write strobe, a channel index and a data word write one register. The register that the index selects is always visible on the read bus. The delay of the staged NMI-then-reset sequence is counted in ticks of a slow clock enable. The `tick_en` input carries that enable, and in the target system it pulses once every six core clocks. Reset is asynchronous and active low. The block releases it internally through a two-flop synchronizer.

Top module: `wdog_rst_router`

## Requirements
- R1: The register layout is as follows. Bits 8:6 hold the delay code, bit 4 is the status flag, bits 3:1 hold the mode code and bit 0 is the lock. Bits 31:9 and bit 5 read as zero. After reset every channel reads 0x100. A channel index of NUM_CH or more reads zero and ignores writes.
- R2: Mode 000 produces no output for an event. The reserved codes 001, 110 and 111 behave the same as mode 000.
- R3: In mode 010, an event drives `lrst_o` high in the clock cycle after the cycle in which the event was sampled.
- R4: In mode 011, an event drives `nmi_o` high in the clock cycle after the cycle in which the event was sampled.
- R5: In mode 100, an event drives `nmi_o` on the same timing as R4. The channel then pulses `lrst_o` right after the tick on which it has counted 2^(BASE_LOG2+delay) ticks, counting only ticks that arrive after the event cycle. Clock cycles without `tick_en` do not count.
- R6: In mode 101, an event drives `srst_o` high in the clock cycle after the cycle in which the event was sampled.
- R7: An event sets the channel's status flag. A write with bit 4 equal to 0 clears the flag. A write with bit 4 equal to 1 leaves the flag unchanged.
- R8: While the lock is 1, writes leave the delay, mode and lock fields unchanged, but a write can still clear the status flag. Only reset clears the lock.
- R9: An event that reaches a channel while its mode-100 delay is running causes no output, and the running delay continues unchanged.
- R10: Each output is a pulse one clock wide per action. When several channels request the same output in the same cycle, they produce that single pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| ch_sel | input | 3 | Channel index for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register of the selected channel |
| evt_in | input | 6 | Timer event per channel, sampled each clock |
| tick_en | input | 1 | Slow-clock tick enable for the delay count |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| lrst_o | output | 1 | Local core reset pulse |
| srst_o | output | 1 | System reset request pulse |

## Verification
Each channel's state is a mode, a delay, a lock, a status flag and a running count. A wrong mode or delay field appears as soon as the register is read back. It also shows one cycle after the next event, as a pulse on the wrong output. A count that is off shows as a `lrst_o` pulse one or more ticks too early or too late. The bench measures that gap against 2^(BASE_LOG2+delay) for every delay code. A lock or status flag that leaks shows on the read bus right after the write that should have been blocked or applied.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int DLY_W   = 3;
  localparam int MODE_W  = 3;
  localparam int LOCK_B  = 0;
  localparam int MODE_LO = 1;
  localparam int STAT_B  = 4;
  localparam int DLY_LO  = 6;
  localparam int DATA_W  = 32;
  localparam logic [DLY_W-1:0] DLY_RST = 3'b100;

  typedef enum logic [MODE_W-1:0] {
    MODE_NONE     = 3'b000,
    MODE_LRST     = 3'b010,
    MODE_NMI      = 3'b011,
    MODE_NMI_LRST = 3'b100,
    MODE_SRST     = 3'b101
  } mode_e;
endpackage

// File: rtl/wdr_chan_cfg.sv
module wdr_chan_cfg
  import wdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt,
  output logic [DLY_W-1:0]  dly,
  output logic [MODE_W-1:0] mode,
  output logic              lock,
  output logic              stat
);
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              lock_q, lock_d, stat_q, stat_d;

  always_comb begin
    dly_d  = dly_q;
    mode_d = mode_q;
    lock_d = lock_q;
    stat_d = stat_q;
    if (wr_hit) begin
      if (!lock_q) begin
        dly_d  = wr_data[DLY_LO +: DLY_W];
        mode_d = wr_data[MODE_LO +: MODE_W];
        lock_d = wr_data[LOCK_B];
      end
      if (!wr_data[STAT_B]) stat_d = 1'b0;
    end
    if (evt) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= DLY_RST;
      mode_q <= MODE_NONE;
      lock_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      dly_q  <= dly_d;
      mode_q <= mode_d;
      lock_q <= lock_d;
      stat_q <= stat_d;
    end
  end

  assign dly  = dly_q;
  assign mode = mode_q;
  assign lock = lock_q;
  assign stat = stat_q;
endmodule

// File: rtl/wdr_chan_seq.sv
module wdr_chan_seq
  import wdr_pkg::*;
#(
  parameter int BASE_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              evt,
  input  logic [MODE_W-1:0] mode,
  input  logic [DLY_W-1:0]  dly,
  output logic              nmi_req,
  output logic              lrst_req,
  output logic              srst_req
);
  localparam int CNT_W = BASE_LOG2 + (1 << DLY_W) - 1;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [CNT_W:0]   span, span_m1;
  logic             accept, fire;

  always_comb begin
    span    = (CNT_W+1)'(1) << (BASE_LOG2 + int'(dly));
    span_m1 = span - (CNT_W+1)'(1);
  end

  assign accept   = evt && !busy_q;
  assign fire     = busy_q && tick_en && (cnt_q == lim_q);
  assign nmi_req  = accept && ((mode == MODE_NMI) || (mode == MODE_NMI_LRST));
  assign srst_req = accept && (mode == MODE_SRST);
  assign lrst_req = (accept && (mode == MODE_LRST)) || fire;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    if (accept && (mode == MODE_NMI_LRST)) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      lim_d  = span_m1[CNT_W-1:0];
    end else if (busy_q && tick_en) begin
      if (fire) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
    end
  end
endmodule

// File: rtl/wdog_rst_router.sv
module wdog_rst_router
  import wdr_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int BASE_LOG2 = 8,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] evt_in,
  input  logic              tick_en,
  output logic              nmi_o,
  output logic              lrst_o,
  output logic              srst_o
);
  localparam int CFG_W = DLY_W + MODE_W;

  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic [NUM_CH-1:0][DLY_W-1:0]  dly_v;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_v;
  logic [NUM_CH-1:0][CFG_W-1:0]  cfg_v;
  logic [NUM_CH-1:0] lock_v, stat_v, nmi_rv, lrst_rv, srst_rv;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr_hit;
    assign wr_hit   = wr_en && (ch_sel == CH_W'(i));
    assign cfg_v[i] = {dly_v[i], mode_v[i]};

    wdr_chan_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_hit  (wr_hit),
      .wr_data (wr_data),
      .evt     (evt_in[i]),
      .dly     (dly_v[i]),
      .mode    (mode_v[i]),
      .lock    (lock_v[i]),
      .stat    (stat_v[i])
    );

    wdr_chan_seq #(.BASE_LOG2(BASE_LOG2)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .tick_en  (tick_en),
      .evt      (evt_in[i]),
      .mode     (mode_v[i]),
      .dly      (dly_v[i]),
      .nmi_req  (nmi_rv[i]),
      .lrst_req (lrst_rv[i]),
      .srst_req (srst_rv[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_W'(i)) begin
        rd_data[DLY_LO +: DLY_W]   = dly_v[i];
        rd_data[STAT_B]            = stat_v[i];
        rd_data[MODE_LO +: MODE_W] = mode_v[i];
        rd_data[LOCK_B]            = lock_v[i];
      end
    end
  end

  logic nmi_d, lrst_d, srst_d, nmi_q, lrst_q, srst_q;
  always_comb begin
    nmi_d  = |nmi_rv;
    lrst_d = |lrst_rv;
    srst_d = |srst_rv;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      nmi_q  <= 1'b0;
      lrst_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_d;
      lrst_q <= lrst_d;
      srst_q <= srst_d;
    end
  end

  assign nmi_o  = nmi_q;
  assign lrst_o = lrst_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [CH_W-1:0]        ch_sel,
  input logic [31:0]            wr_data,
  input logic [31:0]            rd_data,
  input logic [NUM_CH-1:0]      evt_in,
  input logic                   nmi_o,
  input logic                   srst_o,
  input logic [NUM_CH-1:0]      lock_v,
  input logic [NUM_CH-1:0]      stat_v,
  input logic [NUM_CH-1:0][5:0] cfg_v
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:9] == '0) && !rd_data[5]); // R1

  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(|evt_in)); // R4

  AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> $past(|evt_in)); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_v & $past(lock_v)) == $past(lock_v))); // R8

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_LOCK_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      lock_v[i] |=> $stable(cfg_v[i])); // R8

    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_v[i]) |-> $past(wr_en && (ch_sel == CH_W'(i)) && !wr_data[4])); // R7
  end
endmodule

bind wdog_rst_router wdr_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_wdr_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .ch_sel  (ch_sel),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .evt_in  (evt_in),
  .nmi_o   (nmi_o),
  .srst_o  (srst_o),
  .lock_v  (lock_v),
  .stat_v  (stat_v),
  .cfg_v   (cfg_v)
);

// File: tb/wdog_rst_router_bench.sv
module wdog_rst_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 6;
  localparam int BL2  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  ch_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  evt_in = '0;
  logic        tick_en = 1'b0;
  logic        nmi_o, lrst_o, srst_o;

  int n_tests = 0;
  int n_fail  = 0;
  int tdiv    = 0;
  int ticks_seen = 0;

  wdog_rst_router #(.NUM_CH(NCH), .BASE_LOG2(BL2)) u_wdog_rst_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ch_sel(ch_sel),
    .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in),
    .tick_en(tick_en), .nmi_o(nmi_o), .lrst_o(lrst_o), .srst_o(srst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    = (tdiv == 5) ? 0 : tdiv + 1;
    tick_en = (tdiv == 5);
  end
  always @(posedge clk) if (tick_en) ticks_seen++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [31:0] d);
    @(negedge clk);
    ch_sel = 3'(ch); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(int ch, output logic [31:0] d);
    @(negedge clk);
    ch_sel = 3'(ch);
    #1 d = rd_data;
  endtask

  // drives one event cycle; returns at the negedge after the capturing edge
  task automatic pulse(logic [5:0] m);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic wait_lrst(int maxc, output int found);
    found = 0;
    for (int c = 0; c < maxc && found == 0; c++) begin
      if (lrst_o) found = 1;
      else @(negedge clk);
    end
  endtask

  task automatic quiet(string req, int cyc);
    logic seen = 1'b0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      seen |= nmi_o | lrst_o | srst_o;
    end
    chk(req, 32'(seen), 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int found, t0, gap;
    do_reset();

    // R1: reset value and out-of-range index
    for (int c = 0; c < NCH; c++) begin
      rd(c, v); chk("R1 reset value", v, 32'h100);
    end
    wr(6, 32'h1CE);
    rd(6, v); chk("R1 index 6 reads zero", v, 32'h0);
    rd(7, v); chk("R1 index 7 reads zero", v, 32'h0);
    quiet("R1 out-of-range write no output", 4);

    // Mode sweep on every channel: R2 R3 R4 R5 R6 R7
    for (int c = 0; c < NCH; c++) begin
      for (int m = 0; m < 8; m++) begin
        wr(c, 32'(m << 1));
        rd(c, v); chk("R1 mode field readback", v, 32'(m << 1));
        pulse(6'(1 << c));
        chk("R4/R5 nmi after event", 32'(nmi_o), 32'((m == 3 || m == 4) ? 1 : 0));
        chk("R3 lrst after event", 32'(lrst_o), 32'((m == 2) ? 1 : 0));
        chk("R6 srst after event", 32'(srst_o), 32'((m == 5) ? 1 : 0));
        @(negedge clk);
        chk("R10 one-cycle pulse", 32'(nmi_o | srst_o), 32'd0);
        if (m == 4) begin
          wait_lrst(200, found);
          chk("R5 lrst follows nmi", 32'(found), 32'd1);
          @(negedge clk);
          chk("R10 lrst one-cycle", 32'(lrst_o), 32'd0);
        end else begin
          quiet((m == 0 || m == 1 || m > 5) ? "R2 no output" : "R10 single action", 40);
        end
        rd(c, v); chk("R7 status set", 32'(v[4]), 32'd1);
        wr(c, 32'(m << 1) | 32'h10);
        rd(c, v); chk("R7 write one keeps status", 32'(v[4]), 32'd1);
        wr(c, 32'(m << 1));
        rd(c, v); chk("R7 write zero clears", 32'(v[4]), 32'd0);
      end
    end

    // R5: delay sweep, gap counted in ticks after the event cycle
    for (int d = 0; d < 8; d++) begin
      wr(2, 32'((d << 6) | (4 << 1)));
      pulse(6'b000100);
      t0 = ticks_seen;
      chk("R5 nmi first", 32'(nmi_o), 32'd1);
      wait_lrst(8000, found);
      gap = ticks_seen - t0;
      chk("R5 lrst found", 32'(found), 32'd1);
      chk("R5 tick gap", 32'(gap), 32'((1 << BL2) << d));
      @(negedge clk);
      chk("R5 lrst one pulse", 32'(lrst_o), 32'd0);
    end

    // R9: event during running delay is ignored
    wr(2, 32'((1 << 6) | (4 << 1)));
    pulse(6'b000100);
    t0 = ticks_seen;
    repeat (12) @(negedge clk);
    pulse(6'b000100);
    chk("R9 no nmi on re-event", 32'(nmi_o), 32'd0);
    wait_lrst(2000, found);
    chk("R9 delay unchanged", 32'(ticks_seen - t0), 32'(8));
    wr(2, 32'h0);

    // R10: OR across channels
    wr(0, 32'(3 << 1)); wr(1, 32'(3 << 1)); wr(4, 32'(5 << 1));
    pulse(6'b010011);
    chk("R10 shared nmi", 32'(nmi_o), 32'd1);
    chk("R10 srst with nmi", 32'(srst_o), 32'd1);
    chk("R10 no lrst", 32'(lrst_o), 32'd0);
    @(negedge clk);
    chk("R10 single nmi pulse", 32'(nmi_o), 32'd0);

    // R8: lock behaviour
    wr(3, 32'h87);
    wr(3, 32'h0);
    rd(3, v); chk("R8 locked config held", v, 32'h87);
    pulse(6'b001000);
    chk("R8 locked still routes", 32'(nmi_o), 32'd1);
    rd(3, v); chk("R8 status under lock", v, 32'h97);
    wr(3, 32'h0);
    rd(3, v); chk("R8 clear status while locked", v, 32'h87);

    // R1: reserved bits
    wr(5, 32'hFFFF_FFFF);
    rd(5, v); chk("R1 reserved bits zero", v, 32'h1CF);

    do_reset();
    for (int c = 0; c < NCH; c++) begin
      rd(c, v); chk("R8 reset clears lock", v, 32'h100);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule